// File: doc/BRIEF.md
# Interrupt Request and Enable Register Bank

This block holds the per-line request state of a vectored interrupt controller with up to 32 inputs. External interrupt lines are resynchronised, combined with a software-driven request for each line, and gated by an enable bit. The result is a live pending vector. A separate priority stage consumes that vector.

Software reaches the block through a plain 32-bit word-addressed register port. There are no byte lanes. Both the enable word and the software request word can be written whole. Each also has a write-one-to-set alias and a write-one-to-clear alias, so single lines can change without a read-modify-write. The number of implemented lines is a parameter. Lines above that count are held at zero in every word. A write of all ones followed by a read-back therefore shows which lines exist.

Top module: `irq_req_regs`

## Requirements
- R1: After reset the enable word, the software request word, the synchronised inputs, `pend_vec` and `bus_rdata` are all zero.
- R2: A write to word offset 32 loads the enable word, and a read of offset 32 returns it.
- R3: A write to offset 33 sets every enable bit whose data bit is 1 and leaves bits written 0 unchanged.
- R4: A write to offset 34 clears every enable bit whose data bit is 1 and leaves bits written 0 unchanged.
- R5: Offset 37 loads and reads the software request word. Offset 38 sets bits written 1 and offset 39 clears bits written 1; bits written 0 are unchanged at both.
- R6: Reads of the alias offsets 33, 34, 38 and 39 return zero.
- R7: Bit n of `pend_vec` and of the word read at offset 35 equals (synchronised input n OR software bit n) AND enable bit n. It follows that condition level by level and is never latched.
- R8: A read of offset 36 returns the synchronised external inputs, whatever the enable word holds.
- R9: A change on `irq_in` reaches raw status and `pend_vec` after exactly two rising clock edges.
- R10: Bits at or above NUM_IRQ read as zero in every word, and writes to them have no effect. Writing 0xFFFFFFFF to offset 32 or 37 and reading it back returns a mask of the implemented lines.
- R11: `bus_rdata` carries the data for a read one cycle after `bus_rd` is sampled and is zero in any other cycle. Unmapped offsets read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_in | input | NUM_IRQ | Asynchronous external interrupt levels |
| bus_addr | input | 6 | Word offset of the access |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, registered |
| pend_vec | output | 32 | Pending vector to the priority stage |

## Verification
The main function is tested with several patterns. A software-only request separates the OR term from the enable gate. A hardware-only request on an enabled line measures the two-edge synchroniser latency. A hardware request on a disabled line shows that raw status ignores the enable while pending does not. Removing an input shows that pending is not latched. A bench model recomputes pending and read data every cycle, which exposes any mismatch in set/clear ordering or read timing. The all-ones probe on a 20-line configuration separates correct masking of absent lines from leakage into the upper bits.

// File: rtl/irq_req_pkg.sv
package irq_req_pkg;

    localparam int unsigned WORD_W = 32;
    localparam int unsigned ADDR_W = 6;

    typedef enum logic [ADDR_W-1:0] {
        OFS_EN      = 6'd32,
        OFS_EN_SET  = 6'd33,
        OFS_EN_CLR  = 6'd34,
        OFS_PEND    = 6'd35,
        OFS_RAW     = 6'd36,
        OFS_SW      = 6'd37,
        OFS_SW_SET  = 6'd38,
        OFS_SW_CLR  = 6'd39
    } reg_ofs_e;

    typedef struct packed {
        logic load;
        logic set;
        logic clr;
    } wr_ctl_t;

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);

    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = async_in;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_out = st_q.s2;

endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg
    import irq_req_pkg::*;
#(
    parameter logic [WORD_W-1:0] IMPL = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  wr_ctl_t           ctl,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] value
);

    logic [WORD_W-1:0] val_d, val_q;

    always_comb begin
        val_d = val_q;
        if (ctl.load) val_d = wdata;
        if (ctl.set)  val_d = val_d | wdata;
        if (ctl.clr)  val_d = val_d & ~wdata;   // clear applied last
        val_d = val_d & IMPL;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) val_q <= '0;
        else        val_q <= val_d;
    end

    assign value = val_q;

endmodule

// File: rtl/irq_req_regs.sv
module irq_req_regs
    import irq_req_pkg::*;
#(
    parameter int unsigned NUM_IRQ = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_IRQ-1:0] irq_in,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_wr,
    input  logic [WORD_W-1:0]  bus_wdata,
    input  logic               bus_rd,
    output logic [WORD_W-1:0]  bus_rdata,
    output logic [WORD_W-1:0]  pend_vec
);

    localparam logic [WORD_W-1:0] IMPL =
        (NUM_IRQ >= WORD_W) ? {WORD_W{1'b1}} : ((WORD_W'(1) << NUM_IRQ) - WORD_W'(1));

    logic [NUM_IRQ-1:0] irq_sync_n;
    logic [WORD_W-1:0]  raw_w;
    logic [WORD_W-1:0]  en_w;
    logic [WORD_W-1:0]  sw_w;
    wr_ctl_t            en_ctl, sw_ctl;

    irq_sync #(.W(NUM_IRQ)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (irq_in),
        .sync_out (irq_sync_n)
    );

    generate
        if (NUM_IRQ < WORD_W) begin : g_pad
            assign raw_w = {{(WORD_W-NUM_IRQ){1'b0}}, irq_sync_n};
        end else begin : g_full
            assign raw_w = irq_sync_n[WORD_W-1:0];
        end
    endgenerate

    always_comb begin
        en_ctl.load = bus_wr && (bus_addr == OFS_EN);
        en_ctl.set  = bus_wr && (bus_addr == OFS_EN_SET);
        en_ctl.clr  = bus_wr && (bus_addr == OFS_EN_CLR);
        sw_ctl.load = bus_wr && (bus_addr == OFS_SW);
        sw_ctl.set  = bus_wr && (bus_addr == OFS_SW_SET);
        sw_ctl.clr  = bus_wr && (bus_addr == OFS_SW_CLR);
    end

    irq_mask_reg #(.IMPL(IMPL)) u_en (
        .clk   (clk),
        .rst_n (rst_n),
        .ctl   (en_ctl),
        .wdata (bus_wdata),
        .value (en_w)
    );

    irq_mask_reg #(.IMPL(IMPL)) u_sw (
        .clk   (clk),
        .rst_n (rst_n),
        .ctl   (sw_ctl),
        .wdata (bus_wdata),
        .value (sw_w)
    );

    assign pend_vec = (raw_w | sw_w) & en_w;

    typedef struct packed {
        logic [WORD_W-1:0] rdata;
    } rd_t;

    rd_t rd_d, rd_q;

    always_comb begin
        rd_d.rdata = '0;
        if (bus_rd) begin
            case (bus_addr)
                OFS_EN:   rd_d.rdata = en_w;
                OFS_PEND: rd_d.rdata = pend_vec;
                OFS_RAW:  rd_d.rdata = raw_w;
                OFS_SW:   rd_d.rdata = sw_w;
                default:  rd_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign bus_rdata = rd_q.rdata;

    AST_EN_SET_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_EN_SET) |=>
        ((en_w & $past(bus_wdata) & IMPL) == ($past(bus_wdata) & IMPL))); // R3

    AST_EN_CLR_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_EN_CLR) |=> ((en_w & $past(bus_wdata)) == '0)); // R4

    AST_SW_CLR_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_SW_CLR) |=> ((sw_w & $past(bus_wdata)) == '0)); // R5

    AST_REGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> ($stable(en_w) && $stable(sw_w))); // R5

    AST_ALIAS_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && (bus_addr == OFS_EN_SET || bus_addr == OFS_EN_CLR ||
                    bus_addr == OFS_SW_SET || bus_addr == OFS_SW_CLR)) |=> (bus_rdata == '0)); // R6

    AST_IDLE_RDATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> (bus_rdata == '0)); // R11

    AST_ABSENT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (((en_w | sw_w | pend_vec | bus_rdata) & ~IMPL) == '0)); // R10

endmodule

// File: tb/irq_req_regs_tb.sv
module irq_req_regs_tb;

    localparam int NIRQ = 20;
    localparam logic [31:0] MASK = 32'h000F_FFFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [NIRQ-1:0] irq_in = '0;
    logic [5:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic [31:0] pend_vec;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    irq_req_regs #(.NUM_IRQ(NIRQ)) u_dut (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rd(bus_rd),
        .bus_rdata(bus_rdata), .pend_vec(pend_vec)
    );

    // behavioural reference model
    logic [31:0] m_en, m_sw, m_s1, m_s2, m_rd;

    function automatic logic [31:0] m_pend();
        return (m_s2 | m_sw) & m_en;
    endfunction

    function automatic logic [31:0] m_read(input logic [5:0] a);
        case (a)
            6'd32:   return m_en;
            6'd35:   return m_pend();
            6'd36:   return m_s2;
            6'd37:   return m_sw;
            default: return 32'h0;
        endcase
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_en <= '0; m_sw <= '0; m_s1 <= '0; m_s2 <= '0; m_rd <= '0;
        end else begin
            m_rd <= bus_rd ? m_read(bus_addr) : 32'h0;
            if (bus_wr) begin
                case (bus_addr)
                    6'd32: m_en <= bus_wdata & MASK;
                    6'd33: m_en <= (m_en | bus_wdata) & MASK;
                    6'd34: m_en <= m_en & ~bus_wdata;
                    6'd37: m_sw <= bus_wdata & MASK;
                    6'd38: m_sw <= (m_sw | bus_wdata) & MASK;
                    6'd39: m_sw <= m_sw & ~bus_wdata;
                    default: ;
                endcase
            end
            m_s1 <= 32'(irq_in);
            m_s2 <= m_s1;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    // compare with model on every clock
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R7 pend_vec vs model", pend_vec, m_pend());
            chk("R11 bus_rdata vs model", bus_rdata, m_rd);
        end
    end

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        chk("R1 pend after reset", pend_vec, 32'h0);
        chk("R1 rdata after reset", bus_rdata, 32'h0);
        rst_n = 1'b1;
        for (int a = 32; a < 40; a++) begin
            rd(6'(a), v);
            chk("R1 register zero after reset", v, 32'h0);
        end

        wr(6'd32, 32'hFFFF_FFFF);
        rd(6'd32, v); chk("R10 R2 enable all-ones probe", v, MASK);
        wr(6'd32, 32'h0000_0A0A);
        rd(6'd32, v); chk("R2 enable load", v, 32'h0000_0A0A);
        wr(6'd32, 32'h0);
        wr(6'd33, 32'h5);
        rd(6'd32, v); chk("R3 set alias", v, 32'h5);
        wr(6'd33, 32'h10);
        rd(6'd32, v); chk("R3 zeros unchanged", v, 32'h15);
        wr(6'd34, 32'h4);
        rd(6'd32, v); chk("R4 clear alias", v, 32'h11);
        rd(6'd33, v); chk("R6 enable set alias reads zero", v, 32'h0);
        rd(6'd34, v); chk("R6 enable clear alias reads zero", v, 32'h0);

        wr(6'd37, 32'h300);
        rd(6'd37, v); chk("R5 sw load", v, 32'h300);
        wr(6'd38, 32'h1);
        rd(6'd37, v); chk("R5 sw set alias", v, 32'h301);
        wr(6'd39, 32'h100);
        rd(6'd37, v); chk("R5 sw clear alias", v, 32'h201);
        rd(6'd38, v); chk("R6 sw set alias reads zero", v, 32'h0);
        rd(6'd39, v); chk("R6 sw clear alias reads zero", v, 32'h0);

        chk("R7 software-only pending", pend_vec, 32'h1);
        rd(6'd35, v); chk("R7 pending register", v, 32'h1);

        @(negedge clk); irq_in = 20'h00010;
        @(negedge clk); chk("R9 one edge not yet visible", pend_vec, 32'h1);
        @(negedge clk); chk("R9 visible after two edges", pend_vec, 32'h11);
        rd(6'd36, v); chk("R8 raw status enabled line", v, 32'h10);

        @(negedge clk); irq_in = 20'h80000;
        repeat (2) @(negedge clk);
        rd(6'd36, v); chk("R8 raw status disabled line", v, 32'h80000);
        chk("R8 disabled line not pending", pend_vec, 32'h1);

        @(negedge clk); irq_in = '0;
        repeat (2) @(negedge clk);
        chk("R7 pending drops with input", pend_vec, 32'h1);
        wr(6'd39, 32'h1);
        chk("R7 pending drops with software bit", pend_vec, 32'h0);

        wr(6'd37, 32'hFFFF_FFFF);
        rd(6'd37, v); chk("R10 sw all-ones probe", v, MASK);
        wr(6'd37, 32'h0);
        wr(6'd38, 32'hFFF0_0000);
        rd(6'd37, v); chk("R10 absent bits ignore set", v, 32'h0);
        wr(6'd33, 32'hFFF0_0000);
        rd(6'd32, v); chk("R10 absent enable bits ignore set", v, 32'h11);

        rd(6'd5, v); chk("R11 unmapped low offset", v, 32'h0);
        rd(6'd63, v); chk("R11 unmapped high offset", v, 32'h0);
        rd(6'd32, v); chk("R11 read data one cycle after", v, 32'h11);
        @(negedge clk); chk("R11 rdata zero when idle", bus_rdata, 32'h0);

        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule